// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. It finds the one data dependency that forwarding cannot cover: an instruction in decode reads a register that a load, now in execute, has not yet fetched from memory. When it sees this case it holds the fetch address and the decode register for one clock. It also clears the control bundle that would have entered the execute-stage register, so a no-op goes down the pipe in place of the dependent instruction.

The block contains a small model of the stages around the detector. These are the program counter, the fetch/decode register, the decode/execute register and the control part of the execute/memory register. With this model, the hold and bubble behaviour can be seen at the ports. The bubble lets the load move on to the memory stage. On the next clock the condition has gone, and the waiting instruction moves forward with the loaded value one stage closer. Reset is synchronous and fills every modelled stage with a no-op.

Top module: `load_use_stall_top`

## Requirements
- R1: `hz_stall` is high in the same cycle when all three of these hold: bit 0 of `ex_ctl` (the memory-read flag, which marks a load) is set, `ex_dst` is nonzero, and `ex_dst` equals `dec_src_a` or `dec_src_b`.
- R2: A load whose destination field is register 0 never raises `hz_stall`, whatever the decode source fields hold.
- R3: An instruction in execute whose control bit 0 is clear never raises `hz_stall`, even when its destination matches a decode source.
- R4: After a clock edge at which `hz_stall` was high, `pc` keeps its value. After any other edge outside reset, `pc` grows by PC_STEP.
- R5: After a clock edge at which `hz_stall` was high, `dec_src_a`, `dec_src_b` and `dec_ctl` keep their values.
- R6: After a clock edge at which `hz_stall` was high, `ex_ctl` is all zero (a bubble).
- R7: A load in execute raises `hz_stall` for exactly one cycle. In the next cycle the load's control bundle appears on `mem_ctl` and `hz_stall` is low. One cycle after that, the waiting instruction's control appears on `ex_ctl`.
- R8: `pc_wr_en` and `dec_wr_en` are both the inverse of `hz_stall`.
- R9: While `rst` is high at a clock edge, `pc` is loaded with RESET_PC and `dec_ctl`, `ex_ctl`, `mem_ctl`, `ex_dst` and the decode source fields are all zero.
- R10: When no stall occurs, each edge moves the fetch inputs into decode, decode into execute, and the execute control bundle into `mem_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_src_a | input | REG_W | First source field of the fetched instruction |
| fetch_src_b | input | REG_W | Second source field; it is also the destination for a load |
| fetch_ctl | input | CTL_W | Control bundle of the fetched instruction (bit 0 memory read, bit 1 memory write, bit 2 register write, bit 3 write-back from memory) |
| pc_wr_en | output | 1 | Program counter write enable |
| dec_wr_en | output | 1 | Fetch/decode register write enable |
| hz_stall | output | 1 | Clears the control bundle entering execute |
| pc | output | PC_W | Modelled program counter |
| dec_src_a | output | REG_W | First source field held in decode |
| dec_src_b | output | REG_W | Second source field held in decode |
| dec_ctl | output | CTL_W | Control bundle held in decode |
| ex_dst | output | REG_W | Destination field held in execute |
| ex_ctl | output | CTL_W | Control bundle held in execute |
| mem_ctl | output | CTL_W | Control bundle held in the memory stage |

## Verification
The bench builds the block with 5-bit register fields, a 16-bit program counter, a 4-bit control bundle and RESET_PC of 0x0100. The nonzero reset address means a counter that stays cleared is told apart from a real reset load. The narrow register field allows matches on the first source, on the second source, on register 0 and on non-load instructions, all through directed streams. The 16-bit counter lets the bench check the hold and the PC_STEP increment exactly around each bubble.

// File: rtl/lus_pkg.sv
package lus_pkg;
    // bit positions inside the control bundle; the detector decodes bit 0
    localparam int unsigned CTL_MEM_RD    = 0;
    localparam int unsigned CTL_MEM_WR    = 1;
    localparam int unsigned CTL_REG_WR    = 2;
    localparam int unsigned CTL_MEM2REG   = 3;
    localparam int unsigned CTL_MIN_WIDTH = 4;
    // number of decode source fields compared against the load destination
    localparam int unsigned NUM_SRC       = 2;
endpackage

// File: rtl/lus_hazard_detect.sv
module lus_hazard_detect #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned CTL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] ex_ctl_i,
    input  logic [REG_W-1:0] ex_dst_i,
    input  logic [REG_W-1:0] dec_src_a_i,
    input  logic [REG_W-1:0] dec_src_b_i,
    output logic             stall_o
);
    import lus_pkg::*;

    localparam int unsigned NSRC = NUM_SRC;

    logic [NSRC-1:0][REG_W-1:0] src_fields;
    logic [NSRC-1:0]            src_hit;
    logic                       ex_is_load;
    logic                       dst_nonzero;

    always_comb begin
        src_fields[0] = dec_src_a_i;
        src_fields[1] = dec_src_b_i;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src_cmp
        always_comb src_hit[g] = (src_fields[g] == ex_dst_i);
    end

    always_comb begin
        ex_is_load  = ex_ctl_i[CTL_MEM_RD];
        dst_nonzero = (ex_dst_i != '0);
        stall_o     = ex_is_load && dst_nonzero && (|src_hit);
    end

    // R1: a load matching the first decode source must stall
    assert_stall_on_src_a_R1: assert property (@(posedge clk) disable iff (rst)
        (ex_ctl_i[0] && ex_dst_i != '0 && ex_dst_i == dec_src_a_i) |-> stall_o);
    // R1: a load matching the second decode source must stall
    assert_stall_on_src_b_R1: assert property (@(posedge clk) disable iff (rst)
        (ex_ctl_i[0] && ex_dst_i != '0 && ex_dst_i == dec_src_b_i) |-> stall_o);
    // R2: a register-0 destination never stalls
    assert_no_stall_reg0_R2: assert property (@(posedge clk) disable iff (rst)
        (ex_dst_i == '0) |-> !stall_o);
    // R3: only loads stall
    assert_no_stall_nonload_R3: assert property (@(posedge clk) disable iff (rst)
        !ex_ctl_i[0] |-> !stall_o);
endmodule

// File: rtl/lus_stall_ctrl.sv
module lus_stall_ctrl (
    input  logic stall_i,
    output logic pc_we_o,
    output logic dec_we_o,
    output logic ctl_zero_o
);
    always_comb begin
        pc_we_o    = !stall_i;
        dec_we_o   = !stall_i;
        ctl_zero_o = stall_i;
    end

    // R8: both enables drop together and only with the bubble request
    always_comb begin
        assert_enables_match_R8: assert (pc_we_o == dec_we_o);
        assert_bubble_vs_enable_R8: assert (ctl_zero_o != pc_we_o);
    end
endmodule

// File: rtl/lus_pipe_regs.sv
module lus_pipe_regs #(
    parameter int unsigned           REG_W    = 5,
    parameter int unsigned           CTL_W    = 4,
    parameter int unsigned           PC_W     = 32,
    parameter int unsigned           PC_STEP  = 4,
    parameter logic [PC_W-1:0]       RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pc_we_i,
    input  logic             dec_we_i,
    input  logic             ctl_zero_i,
    input  logic [REG_W-1:0] fetch_src_a_i,
    input  logic [REG_W-1:0] fetch_src_b_i,
    input  logic [CTL_W-1:0] fetch_ctl_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [REG_W-1:0] dec_src_a_o,
    output logic [REG_W-1:0] dec_src_b_o,
    output logic [CTL_W-1:0] dec_ctl_o,
    output logic [REG_W-1:0] ex_dst_o,
    output logic [CTL_W-1:0] ex_ctl_o,
    output logic [CTL_W-1:0] mem_ctl_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [REG_W-1:0] dec_src_a;
        logic [REG_W-1:0] dec_src_b;
        logic [CTL_W-1:0] dec_ctl;
        logic [REG_W-1:0] ex_dst;
        logic [CTL_W-1:0] ex_ctl;
        logic [CTL_W-1:0] mem_ctl;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pc_we_i) begin
            st_d.pc = st_q.pc + STEP;
        end
        if (dec_we_i) begin
            st_d.dec_src_a = fetch_src_a_i;
            st_d.dec_src_b = fetch_src_b_i;
            st_d.dec_ctl   = fetch_ctl_i;
        end
        st_d.ex_dst  = st_q.dec_src_b;
        st_d.ex_ctl  = ctl_zero_i ? '0 : st_q.dec_ctl;
        st_d.mem_ctl = st_q.ex_ctl;
        if (rst) begin
            st_d    = '0;
            st_d.pc = RESET_PC;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        pc_o        = st_q.pc;
        dec_src_a_o = st_q.dec_src_a;
        dec_src_b_o = st_q.dec_src_b;
        dec_ctl_o   = st_q.dec_ctl;
        ex_dst_o    = st_q.ex_dst;
        ex_ctl_o    = st_q.ex_ctl;
        mem_ctl_o   = st_q.mem_ctl;
    end

    // R4: the counter holds over a stall and steps otherwise
    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !pc_we_i |=> pc_o == $past(pc_o));
    assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
        pc_we_i |=> pc_o == $past(pc_o) + STEP);
    // R5: decode contents frozen over a stall
    assert_dec_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !dec_we_i |=> $stable(dec_src_a_o) && $stable(dec_src_b_o) && $stable(dec_ctl_o));
    // R6: the bubble carries no control
    assert_bubble_zero_R6: assert property (@(posedge clk) disable iff (rst)
        ctl_zero_i |=> ex_ctl_o == '0);
    // R10: execute control advances into the memory stage
    assert_mem_follows_ex_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> mem_ctl_o == $past(ex_ctl_o));
endmodule

// File: rtl/load_use_stall_top.sv
module load_use_stall_top #(
    parameter int unsigned     REG_W    = 5,
    parameter int unsigned     CTL_W    = 4,
    parameter int unsigned     PC_W     = 32,
    parameter int unsigned     PC_STEP  = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] fetch_src_a,
    input  logic [REG_W-1:0] fetch_src_b,
    input  logic [CTL_W-1:0] fetch_ctl,
    output logic             pc_wr_en,
    output logic             dec_wr_en,
    output logic             hz_stall,
    output logic [PC_W-1:0]  pc,
    output logic [REG_W-1:0] dec_src_a,
    output logic [REG_W-1:0] dec_src_b,
    output logic [CTL_W-1:0] dec_ctl,
    output logic [REG_W-1:0] ex_dst,
    output logic [CTL_W-1:0] ex_ctl,
    output logic [CTL_W-1:0] mem_ctl
);
    import lus_pkg::*;

    if (CTL_W < CTL_MIN_WIDTH) begin : g_bad_ctl_w
        initial $error("CTL_W below minimum control width");
    end

    logic stall_raw;

    lus_hazard_detect #(.REG_W(REG_W), .CTL_W(CTL_W)) u_detect (
        .clk         (clk),
        .rst         (rst),
        .ex_ctl_i    (ex_ctl),
        .ex_dst_i    (ex_dst),
        .dec_src_a_i (dec_src_a),
        .dec_src_b_i (dec_src_b),
        .stall_o     (stall_raw)
    );

    lus_stall_ctrl u_ctrl (
        .stall_i    (stall_raw),
        .pc_we_o    (pc_wr_en),
        .dec_we_o   (dec_wr_en),
        .ctl_zero_o (hz_stall)
    );

    lus_pipe_regs #(
        .REG_W(REG_W), .CTL_W(CTL_W), .PC_W(PC_W),
        .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
    ) u_pipe (
        .clk           (clk),
        .rst           (rst),
        .pc_we_i       (pc_wr_en),
        .dec_we_i      (dec_wr_en),
        .ctl_zero_i    (hz_stall),
        .fetch_src_a_i (fetch_src_a),
        .fetch_src_b_i (fetch_src_b),
        .fetch_ctl_i   (fetch_ctl),
        .pc_o          (pc),
        .dec_src_a_o   (dec_src_a),
        .dec_src_b_o   (dec_src_b),
        .dec_ctl_o     (dec_ctl),
        .ex_dst_o      (ex_dst),
        .ex_ctl_o      (ex_ctl),
        .mem_ctl_o     (mem_ctl)
    );

    // R7: the load leaves execute behind a bubble, so a stall never repeats
    assert_single_cycle_stall_R7: assert property (@(posedge clk) disable iff (rst)
        hz_stall |=> !hz_stall);
    // R9: reset leaves no control anywhere in the modelled stages
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (dec_ctl == '0 && ex_ctl == '0 && mem_ctl == '0 && pc == RESET_PC));
endmodule

// File: tb/load_use_stall_tb.sv
module load_use_stall_top_tb_top;
    localparam int unsigned     REG_W    = 5;
    localparam int unsigned     CTL_W    = 4;
    localparam int unsigned     PC_W     = 16;
    localparam int unsigned     PC_STEP  = 4;
    localparam logic [PC_W-1:0] RESET_PC = 16'h0100;
    localparam time             CLK_PERIOD = 10ns;

    // control encodings: bit0 mem read, bit1 mem write, bit2 reg write, bit3 mem-to-reg
    localparam logic [CTL_W-1:0] C_LOAD  = 4'b1101;
    localparam logic [CTL_W-1:0] C_ALU   = 4'b0100;
    localparam logic [CTL_W-1:0] C_STORE = 4'b0010;
    localparam logic [CTL_W-1:0] C_NOP   = 4'b0000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [REG_W-1:0] fetch_src_a = '0;
    logic [REG_W-1:0] fetch_src_b = '0;
    logic [CTL_W-1:0] fetch_ctl   = '0;
    logic             pc_wr_en, dec_wr_en, hz_stall;
    logic [PC_W-1:0]  pc;
    logic [REG_W-1:0] dec_src_a, dec_src_b, ex_dst;
    logic [CTL_W-1:0] dec_ctl, ex_ctl, mem_ctl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_use_stall_top #(
        .REG_W(REG_W), .CTL_W(CTL_W), .PC_W(PC_W),
        .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
    ) dut_i (
        .clk(clk), .rst(rst),
        .fetch_src_a(fetch_src_a), .fetch_src_b(fetch_src_b), .fetch_ctl(fetch_ctl),
        .pc_wr_en(pc_wr_en), .dec_wr_en(dec_wr_en), .hz_stall(hz_stall),
        .pc(pc), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_ctl(dec_ctl),
        .ex_dst(ex_dst), .ex_ctl(ex_ctl), .mem_ctl(mem_ctl)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic feed(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                        input logic [CTL_W-1:0] c);
        fetch_src_a = a;
        fetch_src_b = b;
        fetch_ctl   = c;
    endtask

    task automatic drain();
        feed(0, 0, C_NOP);
        repeat (3) tick();
    endtask

    task automatic test_reset();
        feed(7, 7, C_LOAD);
        rst = 1'b1;
        repeat (3) tick();
        check("R9", "pc", pc, RESET_PC);
        check("R9", "dec_ctl", dec_ctl, 0);
        check("R9", "ex_ctl", ex_ctl, 0);
        check("R9", "mem_ctl", mem_ctl, 0);
        check("R9", "ex_dst", ex_dst, 0);
        check("R9", "dec_src_a", dec_src_a, 0);
        check("R8", "pc_wr_en", pc_wr_en, 1);
        check("R8", "dec_wr_en", dec_wr_en, 1);
        check("R8", "hz_stall", hz_stall, 0);
        feed(0, 0, C_NOP);
        rst = 1'b0;
    endtask

    task automatic test_flow();
        logic [PC_W-1:0] p0;
        drain();
        p0 = pc;
        feed(3, 4, C_ALU);
        tick();
        check("R10", "dec_ctl after fetch", dec_ctl, C_ALU);
        check("R10", "dec_src_b", dec_src_b, 4);
        check("R4", "pc step", pc, p0 + PC_STEP);
        feed(5, 6, C_STORE);
        tick();
        check("R10", "ex_ctl", ex_ctl, C_ALU);
        check("R10", "ex_dst", ex_dst, 4);
        check("R10", "dec_ctl second", dec_ctl, C_STORE);
        feed(0, 0, C_NOP);
        tick();
        check("R10", "mem_ctl", mem_ctl, C_ALU);
        check("R4", "pc after three steps", pc, p0 + 3 * PC_STEP);
        check("R1", "no stall on plain flow", hz_stall, 0);
    endtask

    task automatic test_load_use(input string tag, input logic [REG_W-1:0] dst,
                                 input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
        logic [PC_W-1:0] p0;
        drain();
        feed(1, dst, C_LOAD);
        tick();
        feed(a, b, C_ALU);
        tick();
        check("R1", {tag, " hz_stall"}, hz_stall, 1);
        check("R8", {tag, " pc_wr_en"}, pc_wr_en, 0);
        check("R8", {tag, " dec_wr_en"}, dec_wr_en, 0);
        p0 = pc;
        feed(9, 9, C_STORE);
        tick();
        check("R4", {tag, " pc held"}, pc, p0);
        check("R5", {tag, " dec_src_a held"}, dec_src_a, a);
        check("R5", {tag, " dec_src_b held"}, dec_src_b, b);
        check("R5", {tag, " dec_ctl held"}, dec_ctl, C_ALU);
        check("R6", {tag, " bubble ex_ctl"}, ex_ctl, 0);
        check("R7", {tag, " load in mem"}, mem_ctl, C_LOAD);
        check("R7", {tag, " stall cleared"}, hz_stall, 0);
        tick();
        check("R7", {tag, " dependent in ex"}, ex_ctl, C_ALU);
        check("R7", {tag, " next fetched"}, dec_ctl, C_STORE);
        check("R4", {tag, " pc resumes"}, pc, p0 + PC_STEP);
    endtask

    task automatic test_no_stall(input string req, input string tag,
                                 input logic [CTL_W-1:0] first_ctl,
                                 input logic [REG_W-1:0] dst,
                                 input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
        logic [PC_W-1:0] p0;
        drain();
        feed(2, dst, first_ctl);
        tick();
        feed(a, b, C_ALU);
        tick();
        check(req, {tag, " hz_stall"}, hz_stall, 0);
        check(req, {tag, " pc_wr_en"}, pc_wr_en, 1);
        p0 = pc;
        feed(0, 0, C_NOP);
        tick();
        check(req, {tag, " pc stepped"}, pc, p0 + PC_STEP);
        check(req, {tag, " dependent in ex"}, ex_ctl, C_ALU);
        check(req, {tag, " first in mem"}, mem_ctl, first_ctl);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_flow();
        test_load_use("R1 src_a match", 5, 5, 8);
        test_load_use("R1 src_b match", 12, 3, 12);
        test_load_use("R1 both match", 31, 31, 31);
        test_no_stall("R2", "R2 load to r0", C_LOAD, 0, 0, 0);
        test_no_stall("R3", "R3 alu match", C_ALU, 6, 6, 6);
        test_no_stall("R3", "R3 store match", C_STORE, 7, 7, 1);
        test_no_stall("R1", "R1 load independent", C_LOAD, 10, 11, 9);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule